// File: doc/BRIEF.md
# Address Watchpoint Debug Unit

This block sits beside a processor's address path and watches the linear addresses it issues, before any page translation. It holds a small set of watchpoint slots, each with a base address, a kind of access to catch (instruction fetch, data write, or any data access) and a watched span of one, two or four bytes. Every cycle, the access on the input port is compared against every armed slot. A matching access sets sticky hit flags and may raise a one-cycle trap request.

Software programs the slots through an indexed register port. The port has one address register per slot, a status register that gathers sticky hit flags, and a control register. The control register holds two enable levels per slot: a per-task level and a global level. It also holds a per-task and a global exact-report bit, which gate traps from data slots. A task-switch pulse drops every per-task bit in one cycle and leaves the global bits alone. This lets a slot follow either one task or all tasks.

Register indices: 0 to NUM_SLOTS-1 are the slot addresses, NUM_SLOTS is status, NUM_SLOTS+1 is control. Other indices read zero. Reads are combinational. Writes take effect at the clock edge.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, every address, status and control register reads zero. No slot is armed, trap_o is 0 and match_o is 0.
- R2: Writing an address index stores the full word, and reading that index returns it.
- R3: Control bit 2n is slot n's per-task enable and bit 2n+1 is its global enable. A slot is armed when either enable is set, and an unarmed slot never matches.
- R4: A task_switch pulse clears control bits 0, 2, 4, 6 and bit 8 (the per-task exact-report bit) in that same edge. Bits 1, 3, 5, 7 and bit 9 (the global exact-report bit) keep their values.
- R5: Slot n's kind sits at control bits 16+4n..17+4n. Kind 00 is a fetch slot. It matches only a fetch (acc_kind 00) whose address equals the slot address exactly, and it ignores the span code.
- R6: Kind 01 is a write slot. It matches only a write (acc_kind 01) that overlaps its span.
- R7: Kind 11 matches a read (acc_kind 10) or a write that overlaps its span. It never matches a fetch.
- R8: Kind 10 never matches any access.
- R9: Slot n's span code sits at control bits 18+4n..19+4n, and access size uses the same code: 00 means 1 byte, 01 means 2 bytes, 11 means 4 bytes. Codes 10 and 11 both mean 4 bytes. The watched span is the slot address with its low bits cleared to the span's alignment. A match needs the byte ranges to overlap, and the ranges do not wrap past the top of the address space.
- R10: The edge after a valid access, match_o shows the slots it matched, and those status bits become set. Status bits stay set until software writes the status register. That write replaces the bits, and a hit in the same cycle is ORed in.
- R11: trap_o pulses for one cycle on the edge after a matching access. A fetch-slot hit always traps. A data-slot hit traps only when bit 8 or bit 9 is set, but it still sets status when neither is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Linear address of the access |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read |
| acc_size | input | 2 | Access size code (same as span code) |
| task_switch | input | 1 | One-cycle task-switch pulse |
| trap_o | output | 1 | One-cycle debug-trap request |
| match_o | output | NUM_SLOTS | Slots matched by the previous access |

## Verification
The bench builds the unit with its defaults: four slots and 32-bit addresses. With these values the control layout fills exactly one word, and each slot's kind and span fields sit at fixed, known bit positions. The full address width brings the top-of-space corner into reach, where an unaligned four-byte access must not wrap onto address zero. The bench also covers two slots hitting on one access, a task switch disarming a per-task-only slot while a global slot stays live, and a data hit that sets status with no trap.

// File: rtl/awu_pkg.sv
package awu_pkg;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_READ  = 2'b10;

  localparam logic [1:0] SLOT_FETCH = 2'b00;
  localparam logic [1:0] SLOT_WRITE = 2'b01;
  localparam logic [1:0] SLOT_RSVD  = 2'b10;
  localparam logic [1:0] SLOT_RDWR  = 2'b11;

  // Byte count for a span/size code: 00 -> 1, 01 -> 2, otherwise 4.
  function automatic logic [2:0] span_bytes(input logic [1:0] code);
    case (code)
      2'b00:   span_bytes = 3'd1;
      2'b01:   span_bytes = 3'd2;
      default: span_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/awu_regs.sv
module awu_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 3,
  parameter int CTRL_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [ADDR_W-1:0]     wdata,
  input  logic                  task_switch,
  input  logic [NUM_SLOTS-1:0]  hit_vec,
  output logic [ADDR_W-1:0]     wp_addr [NUM_SLOTS],
  output logic [CTRL_W-1:0]     ctrl_q,
  output logic [NUM_SLOTS-1:0]  status_q,
  output logic [ADDR_W-1:0]     rdata
);

  localparam int STAT_IDX = NUM_SLOTS;
  localparam int CTRL_IDX = NUM_SLOTS + 1;
  localparam int LEX_BIT  = 2 * NUM_SLOTS;

  function automatic logic [CTRL_W-1:0] per_task_bits();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_SLOTS; n++) m[2*n] = 1'b1;
    m[LEX_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [CTRL_W-1:0] TASK_MASK = per_task_bits();

  logic wr_stat, wr_ctrl;
  logic [CTRL_W-1:0]    ctrl_nxt;
  logic [NUM_SLOTS-1:0] status_nxt;

  assign wr_stat = wr_en && (idx == IDX_W'(STAT_IDX));
  assign wr_ctrl = wr_en && (idx == IDX_W'(CTRL_IDX));

  always_comb begin
    ctrl_nxt = wr_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;
    if (task_switch) ctrl_nxt = ctrl_nxt & ~TASK_MASK;
    status_nxt = (wr_stat ? wdata[NUM_SLOTS-1:0] : status_q) | hit_vec;
  end

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_addr
      always_ff @(posedge clk) begin
        if (!rst_n)                               wp_addr[s] <= '0;
        else if (wr_en && idx == IDX_W'(s))       wp_addr[s] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
    end else begin
      ctrl_q   <= ctrl_nxt;
      status_q <= status_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (idx == IDX_W'(s)) rdata = wp_addr[s];
    if (idx == IDX_W'(STAT_IDX)) rdata = ADDR_W'(status_q);
    if (idx == IDX_W'(CTRL_IDX)) rdata = ADDR_W'(ctrl_q);
  end

  // R4: per-task bits are gone the edge after a task switch
  p_tsw_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ((ctrl_q & TASK_MASK) == '0));

  // R4: global bits survive a task switch with no control write
  p_tsw_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !wr_ctrl) |=> ((ctrl_q & ~TASK_MASK) == ($past(ctrl_q) & ~TASK_MASK)));

  // R10: without a status write, no set bit is lost
  p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/awu_slot_match.sv
module awu_slot_match
  import awu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wp_addr,
  input  logic              armed,
  input  logic [1:0]        slot_kind,
  input  logic [1:0]        span_code,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  output logic              hit,
  output logic              is_data
);

  // Overlap of two inclusive byte ranges, computed one bit wider so that
  // neither range wraps past the top of the address space.
  function automatic logic ranges_overlap(input logic [ADDR_W-1:0] base,
                                          input logic [1:0] wcode,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [1:0] acode);
    logic [ADDR_W:0] w_lo, w_hi, a_lo, a_hi, wsz, asz;
    wsz  = (ADDR_W+1)'(span_bytes(wcode));
    asz  = (ADDR_W+1)'(span_bytes(acode));
    w_lo = {1'b0, base} & ~(wsz - 1'b1);
    w_hi = w_lo + wsz - 1'b1;
    a_lo = {1'b0, addr};
    a_hi = a_lo + asz - 1'b1;
    return (a_lo <= w_hi) && (w_lo <= a_hi);
  endfunction

  logic overlap;
  logic kind_ok;

  assign overlap = ranges_overlap(wp_addr, span_code, acc_addr, acc_size);

  always_comb begin
    case (slot_kind)
      SLOT_FETCH: kind_ok = (acc_kind == KIND_FETCH) && (acc_addr == wp_addr);
      SLOT_WRITE: kind_ok = (acc_kind == KIND_WRITE) && overlap;
      SLOT_RDWR:  kind_ok = ((acc_kind == KIND_WRITE) || (acc_kind == KIND_READ)) && overlap;
      default:    kind_ok = 1'b0;
    endcase
  end

  assign hit     = acc_valid && armed && kind_ok;
  assign is_data = slot_kind[0];

  // R3: an unarmed slot stays quiet
  p_unarmed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !hit);

  // R8: the reserved kind never matches
  p_reserved_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind == SLOT_RSVD) |-> !hit);

  // R7: a fetch never hits a data slot
  p_fetch_not_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == KIND_FETCH && is_data) |-> !hit);

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [IDX_W-1:0]     reg_idx,
  input  logic [ADDR_W-1:0]    reg_wdata,
  output logic [ADDR_W-1:0]    reg_rdata,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [1:0]           acc_kind,
  input  logic [1:0]           acc_size,
  input  logic                 task_switch,
  output logic                 trap_o,
  output logic [NUM_SLOTS-1:0] match_o
);

  localparam int CTRL_W     = 8 * NUM_SLOTS;
  localparam int FIELD_BASE = 4 * NUM_SLOTS;
  localparam int LEX_BIT    = 2 * NUM_SLOTS;
  localparam int GEX_BIT    = 2 * NUM_SLOTS + 1;

  logic [ADDR_W-1:0]    wp_addr [NUM_SLOTS];
  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_SLOTS-1:0] status_q;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] data_vec;
  logic                 exact_on;
  logic                 trap_d;

  awu_regs #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .idx(reg_idx),
    .wdata(reg_wdata), .task_switch(task_switch), .hit_vec(hit_vec),
    .wp_addr(wp_addr), .ctrl_q(ctrl_q), .status_q(status_q), .rdata(reg_rdata)
  );

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      awu_slot_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .wp_addr(wp_addr[s]),
        .armed(ctrl_q[2*s] | ctrl_q[2*s+1]),
        .slot_kind(ctrl_q[FIELD_BASE+4*s +: 2]),
        .span_code(ctrl_q[FIELD_BASE+4*s+2 +: 2]),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_size(acc_size),
        .hit(hit_vec[s]), .is_data(data_vec[s])
      );
    end
  endgenerate

  assign exact_on = ctrl_q[LEX_BIT] | ctrl_q[GEX_BIT];
  assign trap_d   = (|(hit_vec & ~data_vec)) | (exact_on & (|(hit_vec & data_vec)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_o  <= 1'b0;
      match_o <= '0;
    end else begin
      trap_o  <= trap_d;
      match_o <= hit_vec;
    end
  end

  // R11: a trap is always accompanied by a reported match
  p_trap_has_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (match_o != '0));

  // R11: with exact reporting off, only a fetch-slot hit can trap
  p_trap_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !exact_on && ((hit_vec & ~data_vec) == '0)) |=> !trap_o);

  // R10: every reported match is recorded in status
  p_match_recorded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_o & ~status_q) == '0));

endmodule

// File: tb/test_addr_watch_unit.sv
module test_addr_watch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  acc_size = '0;
  logic        task_switch = 1'b0;
  logic        trap_o;
  logic [3:0]  match_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  addr_watch_unit i_addr_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_size(acc_size),
    .task_switch(task_switch), .trap_o(trap_o), .match_o(match_o)
  );

  localparam logic [2:0] I_STAT = 3'd4;
  localparam logic [2:0] I_CTRL = 3'd5;
  localparam logic [1:0] K_F = 2'b00, K_W = 2'b01, K_R = 2'b10;

  // control word fields: kind at 16+4n, span at 18+4n
  function automatic logic [31:0] fld(int n, logic [1:0] kind, logic [1:0] span);
    return {28'd0, span, kind} << (16 + 4*n);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_idx = idx;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic [1:0] sz,
                     input logic exp_trap, input logic [3:0] exp_match, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
    check(match_o == exp_match, {tag, " match"}, 32'(match_o), 32'(exp_match));
    check(trap_o == exp_trap, {tag, " trap"}, 32'(trap_o), 32'(exp_trap));
  endtask

  task automatic t_reset;
    check(trap_o == 1'b0, "R1 trap", 32'(trap_o), 0);
    check(match_o == 4'd0, "R1 match", 32'(match_o), 0);
    for (int i = 0; i < 6; i++) rd_chk(3'(i), 32'd0, "R1 reg");
  endtask

  task automatic t_addr_regs;
    wr(3'd0, 32'hDEAD_BEEF); wr(3'd1, 32'h0000_0001);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'h1234_5678);
    rd_chk(3'd0, 32'hDEAD_BEEF, "R2 a0");
    rd_chk(3'd1, 32'h0000_0001, "R2 a1");
    rd_chk(3'd2, 32'hFFFF_FFFF, "R2 a2");
    rd_chk(3'd3, 32'h1234_5678, "R2 a3");
  endtask

  task automatic t_armed;
    wr(3'd0, 32'h100);
    wr(I_CTRL, fld(0, 2'b11, 2'b00) | (1 << 9));
    acc(32'h100, K_R, 2'b00, 1'b0, 4'b0000, "R3 unarmed");
    rd_chk(I_STAT, 32'd0, "R3 status untouched");
    wr(I_CTRL, fld(0, 2'b11, 2'b00) | (1 << 9) | 32'h2);
    acc(32'h100, K_R, 2'b00, 1'b1, 4'b0001, "R3 global arms");
    wr(I_CTRL, fld(0, 2'b11, 2'b00) | (1 << 9) | 32'h1);
    acc(32'h100, K_R, 2'b00, 1'b1, 4'b0001, "R3 local arms");
    wr(I_STAT, 0);
  endtask

  task automatic t_fetch;
    wr(3'd0, 32'h1000);
    wr(I_CTRL, fld(0, 2'b00, 2'b11) | 32'h2);  // no exact bits
    acc(32'h1000, K_F, 2'b00, 1'b1, 4'b0001, "R5 fetch exact");
    @(negedge clk);
    check(trap_o == 1'b0, "R11 one-cycle pulse", 32'(trap_o), 0);
    acc(32'h1001, K_F, 2'b00, 1'b0, 4'b0000, "R5 fetch off by one");
    acc(32'h1000, K_W, 2'b00, 1'b0, 4'b0000, "R5 write at fetch slot");
    wr(I_STAT, 0);
  endtask

  task automatic t_write;
    wr(3'd1, 32'h2000);
    wr(I_CTRL, fld(1, 2'b01, 2'b01) | 32'h8 | (1 << 9));
    acc(32'h2001, K_W, 2'b00, 1'b1, 4'b0010, "R6 write in span");
    acc(32'h2000, K_R, 2'b00, 1'b0, 4'b0000, "R6 read ignored");
    acc(32'h2002, K_W, 2'b00, 1'b0, 4'b0000, "R6 write past span");
    wr(I_STAT, 0);
  endtask

  task automatic t_rdwr;
    wr(3'd2, 32'h3000);
    wr(I_CTRL, fld(2, 2'b11, 2'b00) | 32'h20 | (1 << 9));
    acc(32'h3000, K_R, 2'b00, 1'b1, 4'b0100, "R7 read");
    acc(32'h2FFF, K_W, 2'b01, 1'b1, 4'b0100, "R7 write straddle");
    acc(32'h3000, K_F, 2'b00, 1'b0, 4'b0000, "R7 fetch ignored");
    wr(I_STAT, 0);
  endtask

  task automatic t_reserved;
    wr(3'd3, 32'h4000);
    wr(I_CTRL, fld(3, 2'b10, 2'b11) | 32'hC0 | (1 << 9));
    acc(32'h4000, K_W, 2'b00, 1'b0, 4'b0000, "R8 write");
    acc(32'h4000, K_R, 2'b11, 1'b0, 4'b0000, "R8 read");
    acc(32'h4000, K_F, 2'b00, 1'b0, 4'b0000, "R8 fetch");
    rd_chk(I_STAT, 32'd0, "R8 status");
  endtask

  task automatic t_align;
    wr(3'd0, 32'h1002);
    wr(3'd1, 32'h0);
    wr(I_CTRL, fld(0, 2'b11, 2'b11) | fld(1, 2'b11, 2'b00) | 32'hA | (1 << 9));
    acc(32'h1000, K_R, 2'b00, 1'b1, 4'b0001, "R9 aligned low byte");
    acc(32'h0FFF, K_R, 2'b01, 1'b1, 4'b0001, "R9 straddle below");
    acc(32'h1004, K_R, 2'b00, 1'b0, 4'b0000, "R9 above span");
    acc(32'h0FFC, K_R, 2'b11, 1'b0, 4'b0000, "R9 adjacent below");
    acc(32'hFFFF_FFFE, K_R, 2'b11, 1'b0, 4'b0000, "R9 no wrap to zero");
    wr(I_STAT, 0);
  endtask

  task automatic t_status;
    wr(3'd0, 32'h5000);
    wr(3'd1, 32'h5002);
    wr(I_CTRL, fld(0, 2'b11, 2'b11) | fld(1, 2'b11, 2'b00) | 32'hA | (1 << 9));
    acc(32'h5002, K_W, 2'b00, 1'b1, 4'b0011, "R10 two slots");
    acc(32'h9000, K_W, 2'b00, 1'b0, 4'b0000, "R10 miss");
    rd_chk(I_STAT, 32'h3, "R10 sticky");
    wr(I_STAT, 32'h0);
    rd_chk(I_STAT, 32'h0, "R10 cleared");
    wr(I_STAT, 32'h4);
    rd_chk(I_STAT, 32'h4, "R10 replaced");
    wr(I_STAT, 0);
  endtask

  task automatic t_exact;
    wr(3'd0, 32'h6000);
    wr(I_CTRL, fld(0, 2'b01, 2'b00) | 32'h2);
    acc(32'h6000, K_W, 2'b00, 1'b0, 4'b0001, "R11 data no exact");
    rd_chk(I_STAT, 32'h1, "R11 status set without trap");
    wr(I_CTRL, fld(0, 2'b01, 2'b00) | 32'h2 | (1 << 8));
    acc(32'h6000, K_W, 2'b00, 1'b1, 4'b0001, "R11 data local exact");
    wr(I_STAT, 0);
  endtask

  task automatic t_task_switch;
    logic [31:0] c;
    wr(3'd0, 32'h7000);
    wr(3'd1, 32'h7000);
    c = fld(0, 2'b11, 2'b00) | fld(1, 2'b11, 2'b00) | 32'h0000_0339;
    wr(I_CTRL, c);
    @(negedge clk);
    task_switch = 1'b1;
    @(negedge clk);
    task_switch = 1'b0;
    rd_chk(I_CTRL, c & ~32'h155, "R4 locals cleared globals kept");
    acc(32'h7000, K_R, 2'b00, 1'b1, 4'b0010, "R4 global slot survives");
    wr(I_STAT, 0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_regs();
    t_armed();
    t_fetch();
    t_write();
    t_rdwr();
    t_reserved();
    t_align();
    t_status();
    t_exact();
    t_task_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule